// File: doc/BRIEF.md
# Prescaled Event Timer

This block is a counter/timer peripheral with a small register interface. Strobes on `cntTick` stand for the count clock. A power-of-two prescaler divides them first, and each prescaled count advances a counter. The counter works in one of two ways:

- **Narrow mode:** the low count byte runs up to a period value kept in the high byte register, then wraps.
- **Wide mode:** the two bytes form one free-running 16-bit count that produces an event when it rolls over.

Events pass through a postscaler that divides by 1 to 16. Each postscaled event does three things: it sets a sticky interrupt flag, it flips a square-wave output, and it makes an interrupt request if that is enabled. A sleep input stops a synchronous counter. An asynchronous counter keeps running during sleep and asks for a wake-up when a flagged event occurs.

Software configures the block through four byte registers. Field positions are given in the requirements below. The prescaler and postscaler counts cannot be read. They are cleared as a side effect of writing the control registers or the low count byte.

Top module: `prescaled_timer`

## Requirements
- R1: Register address 1 (setup), bits 3:0 hold a prescaler select S. The counter advances once per 2^S accepted `cntTick` strobes, where S runs from 0 to 15.
- R2: In narrow mode (address 0 bit 6 = 0), the low byte (address 2) counts up. On the count after it equals the high byte (address 3), it returns to 0 and an event occurs. The period is therefore high byte + 1 counts, and the high byte does not change.
- R3: In wide mode (address 0 bit 6 = 1), {address 3, address 2} counts as one 16-bit value with carry. An event occurs when it wraps from FFFFh to 0000h.
- R4: Address 0 bits 3:0 hold a postscaler select P. One postscaled event occurs for every P + 1 events.
- R5: `tmrOut` inverts on each postscaled event. Its level is readable at address 0 bit 5.
- R6: Address 1 bit 7 is the interrupt flag. A postscaled event sets it. Writing 0 to it clears it, and writing 1 to it has no effect. `irq` equals flag AND address 1 bit 6 (interrupt enable).
- R7: A write to address 0, 1 or 2 clears the hidden prescaler and postscaler counts.
- R8: When address 0 bit 7 (run enable) is 0, the counter, prescaler and postscaler hold their values.
- R9: When `sleep` is 1 and address 1 bit 4 (asynchronous) is 0, counting halts. When the asynchronous bit is 1, counting continues. `wakeReq` equals sleep AND asynchronous AND flag AND interrupt enable.
- R10: After reset, all registers read 0 and `tmrOut`, `irq` and `wakeReq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntTick | input | 1 | One strobe per count-clock edge |
| sleep | input | 1 | Device sleep state |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write register address |
| wrData | input | 8 | Write data |
| rdAddr | input | 2 | Read register address |
| rdData | output | 8 | Read data (combinational) |
| tmrOut | output | 1 | Toggling timer output |
| irq | output | 1 | Interrupt request |
| wakeReq | output | 1 | Wake request while sleeping |

## Verification
The bench builds the block with its default parameters: 8-bit count bytes and 4-bit prescaler and postscaler selects. With these values every select code is legal, and the run table mixes prescale ratios, periods and postscale ratios whose expected event counts the bench computes with integer division. To reach the 16-bit rollover in a few cycles, the bench preloads the count just below FFFFh. It also preloads just below a byte carry to check the carry into the high byte. The hidden-count clears are made visible by comparing counts and toggles against what an uncleared scaler would have produced.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  typedef enum logic [1:0] {
    REG_CTLA  = 2'd0,
    REG_SETUP = 2'd1,
    REG_CNTLO = 2'd2,
    REG_CNTHI = 2'd3
  } regSel_e;

  typedef struct packed {
    logic countStep;
    logic loadLo;
    logic loadHi;
  } dpStrobe_t;
endpackage

// File: rtl/ptmr_datapath.sv
module ptmr_datapath
  import ptmr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              wide,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] cntLo,
  output logic [BYTE_W-1:0] cntHi,
  output logic              evtHit
);
  localparam logic [BYTE_W-1:0] ALL_ONES = '1;

  logic                matchNarrow;
  logic                rollWide;
  logic [2*BYTE_W-1:0] wideNext;

  assign matchNarrow = (cntLo == cntHi);
  assign rollWide    = (cntLo == ALL_ONES) && (cntHi == ALL_ONES);
  assign wideNext    = {cntHi, cntLo} + 1'b1;
  assign evtHit      = strb.countStep && (wide ? rollWide : matchNarrow);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntLo <= '0;
      cntHi <= '0;
    end else if (strb.loadLo || strb.loadHi) begin
      if (strb.loadLo) cntLo <= wrData;
      if (strb.loadHi) cntHi <= wrData;
    end else if (strb.countStep) begin
      if (wide) {cntHi, cntLo} <= wideNext;
      else      cntLo <= matchNarrow ? '0 : cntLo + 1'b1;
    end
  end
endmodule

// File: rtl/ptmr_ctrl.sv
module ptmr_ctrl
  import ptmr_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int PRE_SEL_W  = 4,
  parameter int POST_SEL_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cntTick,
  input  logic                  sleep,
  input  logic                  wrEn,
  input  logic [1:0]            wrAddr,
  input  logic [BYTE_W-1:0]     wrData,
  input  logic                  evtHit,
  output dpStrobe_t             strb,
  output logic                  enQ,
  output logic                  wideQ,
  output logic                  asyncQ,
  output logic                  irqEnQ,
  output logic                  flagQ,
  output logic                  outQ,
  output logic [PRE_SEL_W-1:0]  preSel,
  output logic [POST_SEL_W-1:0] postSel
);
  localparam int PRE_CNT_W = (1 << PRE_SEL_W) - 1;
  localparam int EN_BIT    = BYTE_W - 1;
  localparam int WIDE_BIT  = BYTE_W - 2;
  localparam int FLAG_BIT  = BYTE_W - 1;
  localparam int IE_BIT    = BYTE_W - 2;
  localparam int ASYNC_BIT = BYTE_W - 4;

  logic                  wrCtlA, wrSetup, wrLo, wrHi, scalerClr;
  logic                  runOk, preHit, postHit, tickTaken;
  logic [PRE_CNT_W-1:0]  preCnt, preMask;
  logic [POST_SEL_W-1:0] postCnt;

  assign wrCtlA    = wrEn && (wrAddr == REG_CTLA);
  assign wrSetup   = wrEn && (wrAddr == REG_SETUP);
  assign wrLo      = wrEn && (wrAddr == REG_CNTLO);
  assign wrHi      = wrEn && (wrAddr == REG_CNTHI);
  assign scalerClr = wrCtlA || wrSetup || wrLo;

  assign runOk     = enQ && !(sleep && !asyncQ);
  assign tickTaken = cntTick && runOk && !wrEn;
  assign preMask   = (PRE_CNT_W'(1) << preSel) - 1'b1;
  assign preHit    = ((preCnt & preMask) == preMask);
  assign postHit   = evtHit && (postCnt == postSel);

  assign strb.countStep = tickTaken && preHit;
  assign strb.loadLo    = wrLo;
  assign strb.loadHi    = wrHi;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ     <= 1'b0;
      wideQ   <= 1'b0;
      postSel <= '0;
      asyncQ  <= 1'b0;
      irqEnQ  <= 1'b0;
      preSel  <= '0;
    end else begin
      if (wrCtlA) begin
        enQ     <= wrData[EN_BIT];
        wideQ   <= wrData[WIDE_BIT];
        postSel <= wrData[POST_SEL_W-1:0];
      end
      if (wrSetup) begin
        irqEnQ <= wrData[IE_BIT];
        asyncQ <= wrData[ASYNC_BIT];
        preSel <= wrData[PRE_SEL_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          preCnt <= '0;
    else if (scalerClr) preCnt <= '0;
    else if (tickTaken) preCnt <= preHit ? '0 : preCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          postCnt <= '0;
    else if (scalerClr) postCnt <= '0;
    else if (evtHit)    postCnt <= postHit ? '0 : postCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= 1'b0;
      outQ  <= 1'b0;
    end else begin
      if (postHit)                           flagQ <= 1'b1;
      else if (wrSetup && !wrData[FLAG_BIT]) flagQ <= 1'b0;
      if (postHit) outQ <= ~outQ;
    end
  end
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import ptmr_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int PRE_SEL_W  = 4,
  parameter int POST_SEL_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntTick,
  input  logic              sleep,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [1:0]        rdAddr,
  output logic [BYTE_W-1:0] rdData,
  output logic              tmrOut,
  output logic              irq,
  output logic              wakeReq
);
  dpStrobe_t             strb;
  logic                  enQ, wideQ, asyncQ, irqEnQ, flagQ, outQ, evtHit;
  logic [PRE_SEL_W-1:0]  preSel;
  logic [POST_SEL_W-1:0] postSel;
  logic [BYTE_W-1:0]     cntLo, cntHi, ctlAByte, setupByte;

  ptmr_ctrl #(.BYTE_W(BYTE_W), .PRE_SEL_W(PRE_SEL_W), .POST_SEL_W(POST_SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cntTick(cntTick), .sleep(sleep), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .evtHit(evtHit), .strb(strb), .enQ(enQ),
    .wideQ(wideQ), .asyncQ(asyncQ), .irqEnQ(irqEnQ), .flagQ(flagQ), .outQ(outQ),
    .preSel(preSel), .postSel(postSel)
  );

  ptmr_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wide(wideQ), .wrData(wrData),
    .cntLo(cntLo), .cntHi(cntHi), .evtHit(evtHit)
  );

  always_comb begin
    ctlAByte = '0;
    ctlAByte[BYTE_W-1]       = enQ;
    ctlAByte[BYTE_W-2]       = wideQ;
    ctlAByte[BYTE_W-3]       = outQ;
    ctlAByte[POST_SEL_W-1:0] = postSel;
    setupByte = '0;
    setupByte[BYTE_W-1]      = flagQ;
    setupByte[BYTE_W-2]      = irqEnQ;
    setupByte[BYTE_W-4]      = asyncQ;
    setupByte[PRE_SEL_W-1:0] = preSel;
  end

  always_comb begin
    case (rdAddr)
      REG_CTLA:  rdData = ctlAByte;
      REG_SETUP: rdData = setupByte;
      REG_CNTLO: rdData = cntLo;
      default:   rdData = cntHi;
    endcase
  end

  assign tmrOut  = outQ;
  assign irq     = flagQ && irqEnQ;
  assign wakeReq = irq && sleep && asyncQ;
endmodule

// File: rtl/prescaled_timer_chk.sv
module prescaled_timer_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sleep,
  input logic              wrEn,
  input logic [1:0]        wrAddr,
  input logic [BYTE_W-1:0] wrData,
  input logic              tmrOut,
  input logic              irq,
  input logic              wakeReq,
  input logic              flagQ,
  input logic              enQ,
  input logic              asyncQ,
  input logic              wideQ,
  input logic              evtHit,
  input logic [BYTE_W-1:0] cntLo,
  input logic [BYTE_W-1:0] cntHi
);
  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !(wrEn && wrAddr == 2'd1 && !wrData[BYTE_W-1])) |=> flagQ);

  // R5
  out_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(tmrOut) |-> flagQ);

  // R8
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enQ && !wrEn) |=> ($stable(cntLo) && $stable(cntHi)));

  // R9
  sleep_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sleep && !asyncQ && !wrEn) |=> ($stable(cntLo) && $stable(cntHi)));

  // R9
  wake_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> (sleep && irq && flagQ));

  // R2
  narrow_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtHit && !wideQ) |=> (cntLo == '0));

  // R3
  wide_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtHit && wideQ) |=> (cntLo == '0 && cntHi == '0));
endmodule

bind prescaled_timer prescaled_timer_chk #(.BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/prescaled_timer_bench.sv
module prescaled_timer_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cntTick = 1'b0, sleep = 1'b0, wrEn = 1'b0;
  logic [1:0] wrAddr = '0, rdAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       tmrOut, irq, wakeReq;

  int checks = 0, fails = 0, toggles = 0, cycles = 0;
  logic prevOut = 1'b0;
  logic [7:0] v;

  // fields: prescale select, postscale select, period, tick count
  localparam logic [31:0] RUNS [0:5] = '{
    32'h0003_0014, 32'h1204_0064, 32'h3009_0055,
    32'h2F01_00C8, 32'h0100_0007, 32'h1005_0017
  };

  always #2.5 clk = ~clk;

  prescaled_timer u_prescaled_timer (
    .clk(clk), .rstN(rstN), .cntTick(cntTick), .sleep(sleep), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .tmrOut(tmrOut), .irq(irq), .wakeReq(wakeReq)
  );

  always @(negedge clk) begin
    if (tmrOut !== prevOut) toggles++;
    prevOut = tmrOut;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rdAddr = a;
    #1 d = rdData;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    cntTick = 1'b1;
    repeat (n) @(negedge clk);
    cntTick = 1'b0;
  endtask

  task automatic clrToggles();
    @(negedge clk);
    #1 toggles = 0;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10 reset state
    rd(2'd0, v); check("R10 ctlA", v, 0);
    rd(2'd1, v); check("R10 setup", v, 0);
    rd(2'd2, v); check("R10 cntLo", v, 0);
    check("R10 tmrOut", tmrOut, 0);
    check("R10 irq", irq, 0);
    check("R10 wakeReq", wakeReq, 0);

    // R1 R2 R4 R6: table of narrow-mode runs
    for (int i = 0; i < 6; i++) begin
      int pre, post, per, n, pc, ev, tg;
      pre = int'(RUNS[i][31:28]); post = int'(RUNS[i][27:24]);
      per = int'(RUNS[i][23:16]); n = int'(RUNS[i][15:0]);
      pc = n >> pre; ev = pc / (per + 1); tg = ev / (post + 1);
      wr(2'd0, 8'h00);
      wr(2'd1, 8'h40 | 8'(pre));
      wr(2'd3, 8'(per));
      wr(2'd2, 8'h00);
      wr(2'd0, 8'h80 | 8'(post));
      clrToggles();
      ticks(n);
      settle();
      check("R4 postscaled toggles", toggles, tg);
      rd(2'd2, v); check("R1 R2 low byte", v, pc % (per + 1));
      rd(2'd3, v); check("R2 high byte unchanged", v, per);
      rd(2'd1, v); check("R6 flag", v[7], (tg > 0) ? 1 : 0);
      check("R6 irq", irq, (tg > 0) ? 1 : 0);
      rd(2'd0, v); check("R5 status bit", v[5], tmrOut);
    end

    // R6: clear by writing 0, no set by writing 1, irq gated by enable
    wr(2'd1, 8'h00);
    rd(2'd1, v); check("R6 flag cleared", v[7], 0);
    wr(2'd1, 8'h80);
    rd(2'd1, v); check("R6 write one ignored", v[7], 0);
    wr(2'd3, 8'h00); wr(2'd2, 8'h00); wr(2'd0, 8'h80);
    ticks(1); settle();
    rd(2'd1, v); check("R6 flag set ie=0", v[7], 1);
    check("R6 irq masked", irq, 0);

    // R3: wide mode rollover and byte carry
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    wr(2'd3, 8'h12); wr(2'd2, 8'hFF); wr(2'd0, 8'hC0);
    clrToggles();
    ticks(1); settle();
    rd(2'd3, v); check("R3 carry high", v, 8'h13);
    rd(2'd2, v); check("R3 carry low", v, 0);
    check("R3 no event on carry", toggles, 0);
    wr(2'd3, 8'hFF); wr(2'd2, 8'hFE); wr(2'd0, 8'hC0);
    clrToggles();
    ticks(1); settle();
    check("R3 no event at FFFF", toggles, 0);
    ticks(1); settle();
    check("R3 rollover event", toggles, 1);
    rd(2'd3, v); check("R3 wrapped high", v, 0);
    rd(2'd2, v); check("R3 wrapped low", v, 0);

    // R8: run enable off holds the count
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    wr(2'd3, 8'd50); wr(2'd2, 8'h00); wr(2'd0, 8'h80);
    ticks(3);
    wr(2'd0, 8'h00);
    ticks(5); settle();
    rd(2'd2, v); check("R8 hold when off", v, 3);

    // R7: prescaler cleared by low byte write
    wr(2'd1, 8'h02); wr(2'd2, 8'h00); wr(2'd0, 8'h80);
    ticks(3);
    wr(2'd2, 8'h00);
    ticks(3); settle();
    rd(2'd2, v); check("R7 prescaler cleared", v, 0);
    ticks(1); settle();
    rd(2'd2, v); check("R7 prescaler count after clear", v, 1);

    // R7: postscaler cleared by control write
    wr(2'd1, 8'h00); wr(2'd3, 8'h00); wr(2'd2, 8'h00); wr(2'd0, 8'h82);
    clrToggles();
    ticks(2);
    wr(2'd0, 8'h82);
    ticks(2); settle();
    check("R7 postscaler cleared", toggles, 0);
    ticks(1); settle();
    check("R7 postscaler event after clear", toggles, 1);

    // R9: synchronous halt, asynchronous run and wake request
    wr(2'd1, 8'h00); wr(2'd3, 8'd50); wr(2'd2, 8'h00); wr(2'd0, 8'h80);
    sleep = 1'b1;
    ticks(4); settle();
    rd(2'd2, v); check("R9 sync halted", v, 0);
    sleep = 1'b0;
    ticks(2); settle();
    rd(2'd2, v); check("R9 sync resumes", v, 2);
    wr(2'd1, 8'h50); wr(2'd3, 8'h01); wr(2'd2, 8'h00); wr(2'd0, 8'h80);
    sleep = 1'b1;
    settle();
    check("R9 no wake before event", wakeReq, 0);
    ticks(2); settle();
    rd(2'd2, v); check("R9 async counted", v, 0);
    check("R9 wake request", wakeReq, 1);
    sleep = 1'b0;
    settle();
    check("R9 wake drops on exit", wakeReq, 0);
    check("R6 irq stays", irq, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule